// File: doc/BRIEF.md
# Reset and Power-Mode Sequencer

This block sequences reset entry and the two low-power modes for a small 8-bit microcontroller core. It divides the oscillator clock into a machine-cycle timebase of twelve phases. It filters the external reset pin into a qualified core reset. It also produces the clock enables that the CPU and the peripheral logic use. While the pin is high, the port drivers are forced high straight away, without waiting for a clock edge. The core reset is only issued after the pin has been seen high for two whole machine cycles.

Software requests idle or power-down through one-cycle strobes. In idle, the CPU enable drops while the peripheral enable keeps running, and any pending enabled interrupt brings the core back. Power-down stops the oscillator-run output. Only the reset pin can end power-down. When a reset ends an idle period, the CPU briefly resumes before the core reset arrives, and during that window the block tells the RAM to refuse writes. When the core reset begins, a one-cycle strobe tells the special-function registers to load their default values. Those defaults are published on a constant bus, one byte lane per register.

Top module: `rstpwr_ctrl`

## Requirements
- R1: `mc_phase` counts 0 to 11 and wraps to 0, advancing once per clock while `osc_run` is high. `mc_tick` is high exactly when `mc_phase` is 11. While `osc_run` is low the phase holds its value.
- R2: `ports_high` is high whenever `rst_pin` is high, with no clock edge needed. It also stays high while `core_rst` is high.
- R3: `rst_pin` passes through a 2-flop synchronizer before a 24-clock hold count. If the pin rises between two edges, `core_rst` is high after the 26th following edge. A pin pulse covering fewer than 25 edges never raises `core_rst`. After the pin falls, `core_rst` goes low after the 2nd edge.
- R4: `sfr_load` is high only in the first clock cycle of each `core_rst` assertion.
- R5: Each byte lane of `sfr_rst_val` holds one register's reset value, with lane k in bits [8k+7:8k]. The lanes are: 0 stack pointer = 07h, 1 and 2 the two port latches = FFh, and 3 to 14 (accumulator, B, status word, data-pointer low and high, timer control, timer mode, timer low and high, interrupt enable, interrupt priority, power control) = 00h. Bits that a register does not define are 0.
- R6: A one-cycle `idle_req` in run mode sets `pm_mode` to 1 (0 = run, 1 = idle, 2 = power-down) after the next edge. In idle, `cpu_ce` is 0 and both `periph_ce` and `osc_run` stay 1.
- R7: In idle, `irq_pending` returns `pm_mode` to 0 and `cpu_ce` to 1 after the next edge.
- R8: A one-cycle `pdown_req` in run mode sets `pm_mode` to 2 after the next edge. In power-down, `osc_run`, `cpu_ce` and `periph_ce` are all 0, and `irq_pending` and `idle_req` have no effect.
- R9: Power-down ends only through the reset pin. If the pin rises between two edges, `pm_mode` is 0 and `osc_run` is 1 after the 3rd following edge. Because the hold count starts one edge later, `core_rst` then rises after the 27th edge.
- R10: When `idle_req` and `pdown_req` arrive in the same run-mode cycle, power-down wins.
- R11: When the reset pin ends idle, `pm_mode` returns to 0 after the 3rd edge following the pin's rise, and `ram_wr_block` goes high at the same time. `ram_wr_block` stays high until the 2nd edge after the pin falls.
- R12: While `rst_n` is low at a clock edge, the block returns to run mode with phase 0, `core_rst` and `sfr_load` low, and `ram_wr_block` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Block power-on reset, synchronous, active low |
| rst_pin | input | 1 | External reset pin, asynchronous, active high |
| idle_req | input | 1 | Software strobe requesting idle |
| pdown_req | input | 1 | Software strobe requesting power-down |
| irq_pending | input | 1 | An enabled interrupt is pending |
| mc_phase | output | 4 | Machine-cycle phase, 0 to 11 |
| mc_tick | output | 1 | Last phase of the machine cycle |
| core_rst | output | 1 | Qualified core reset |
| cpu_ce | output | 1 | CPU clock enable |
| periph_ce | output | 1 | Peripheral clock enable |
| osc_run | output | 1 | Oscillator run request |
| ports_high | output | 1 | Force all port outputs to 1 |
| sfr_load | output | 1 | Strobe to load register reset values |
| sfr_rst_val | output | 120 | Reset value per register, 8 bits per lane |
| ram_wr_block | output | 1 | Block internal RAM writes |
| pm_mode | output | 2 | Current mode: 0 run, 1 idle, 2 power-down |

## Verification
Reset pulses of random width between 1 and 40 clocks are applied. The core reset must appear exactly when the width reaches the threshold, which separates a correct hold count from one that is off by one clock or that skips synchronization. A random mix of idle, power-down and interrupt strobes is run against a bench mode model, which shows whether the strobes are taken only in the right mode and whether power-down wins over idle. Directed sequences cover the remaining cases: a reset arriving during idle and during power-down, which differ in wake timing and in RAM write blocking; phase freezing in power-down; and a reset pin observed between clock edges.

// File: rtl/rstpwr_pkg.sv
// Package: shared mode encoding and register default values for the
// reset and power-mode sequencer. Assumes 8-bit registers.
package rstpwr_pkg;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_IDLE  = 2'd1,
        MODE_PDOWN = 2'd2
    } pmode_e;

    localparam int SFR_LANES = 15;

    // Default value for byte lane idx: stack pointer, two port latches, rest zero.
    function automatic logic [7:0] sfr_default(input int idx);
        case (idx)
            0:       return 8'h07;
            1, 2:    return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/rpc_sync.sv
// Synchronizer: multi-flop chain that brings an asynchronous level into the
// clock domain. Assumes STAGES >= 2. Chain clears on the block reset.
module rpc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the level one stage per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rpc_mcycle.sv
// Machine-cycle timebase: free-running phase counter that wraps after
// CLKS_PER_MC clocks and holds its value while the oscillator is stopped.
module rpc_mcycle #(
    parameter int CLKS_PER_MC = 12,
    localparam int PW = $clog2(CLKS_PER_MC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    output logic [PW-1:0] phase,
    output logic          tick
);
    localparam logic [PW-1:0] LAST = PW'(CLKS_PER_MC - 1);

    // Advance the phase while the oscillator runs.
    always_ff @(posedge clk) begin
        if (!rst_n)          phase <= '0;
        else if (run)        phase <= (phase == LAST) ? '0 : phase + 1'b1;
    end

    assign tick = (phase == LAST);
endmodule

// File: rtl/rpc_rst_seq.sv
// Reset qualifier: counts clocks with the synchronized pin high and the
// oscillator running, and raises the core reset once HOLD_CLKS are seen.
// Drops the core reset as soon as the synchronized pin falls.
module rpc_rst_seq #(
    parameter int HOLD_CLKS = 24,
    localparam int CW = $clog2(HOLD_CLKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    input  logic run,
    output logic core_rst,
    output logic sfr_load
);
    localparam logic [CW-1:0] HOLD = CW'(HOLD_CLKS);

    logic [CW-1:0] hold_cnt;
    logic          core_q;

    // Saturating hold counter, cleared when the pin is released.
    always_ff @(posedge clk) begin
        if (!rst_n || !pin_s)             hold_cnt <= '0;
        else if (run && hold_cnt != HOLD) hold_cnt <= hold_cnt + 1'b1;
    end

    // Remember the previous core reset level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) core_q <= 1'b0;
        else        core_q <= core_rst;
    end

    assign core_rst = pin_s && (hold_cnt == HOLD);
    assign sfr_load = core_rst && !core_q;
endmodule

// File: rtl/rpc_mode_fsm.sv
// Mode controller: run / idle / power-down state machine. Power-down wins
// over idle, idle leaves on interrupt or reset, power-down leaves only on
// reset. Tracks the window in which a reset is ending idle, to block RAM writes.
module rpc_mode_fsm
    import rstpwr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pin_s,
    input  logic   core_rst,
    input  logic   idle_req,
    input  logic   pdown_req,
    input  logic   irq_pending,
    output pmode_e mode,
    output logic   ram_blk
);
    logic blk_q;

    // Next-mode selection.
    always_ff @(posedge clk) begin
        if (!rst_n || core_rst) begin
            mode <= MODE_RUN;
        end else begin
            case (mode)
                MODE_RUN: begin
                    if (!pin_s && pdown_req)     mode <= MODE_PDOWN;
                    else if (!pin_s && idle_req) mode <= MODE_IDLE;
                end
                MODE_IDLE:  if (irq_pending || pin_s) mode <= MODE_RUN;
                MODE_PDOWN: if (pin_s)                mode <= MODE_RUN;
                default:    mode <= MODE_RUN;
            endcase
        end
    end

    // Latch that a reset is ending idle; hold until the pin is released.
    always_ff @(posedge clk) begin
        if (!rst_n) blk_q <= 1'b0;
        else        blk_q <= pin_s && (blk_q || mode == MODE_IDLE);
    end

    assign ram_blk = blk_q && pin_s;
endmodule

// File: rtl/rstpwr_ctrl.sv
// Top: reset and power-mode sequencer. Combines the pin synchronizer,
// machine-cycle timebase, reset qualifier and mode controller. Assumes the
// clock keeps toggling in power-down so that the pin can wake the block;
// osc_run tells the oscillator whether to run.
module rstpwr_ctrl
    import rstpwr_pkg::*;
#(
    parameter int CLKS_PER_MC = 12,
    parameter int HOLD_MC     = 2,
    parameter int SYNC_STAGES = 2,
    localparam int PW        = $clog2(CLKS_PER_MC),
    localparam int HOLD_CLKS = CLKS_PER_MC * HOLD_MC,
    localparam int SFR_W     = SFR_LANES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rst_pin,
    input  logic             idle_req,
    input  logic             pdown_req,
    input  logic             irq_pending,
    output logic [PW-1:0]    mc_phase,
    output logic             mc_tick,
    output logic             core_rst,
    output logic             cpu_ce,
    output logic             periph_ce,
    output logic             osc_run,
    output logic             ports_high,
    output logic             sfr_load,
    output logic [SFR_W-1:0] sfr_rst_val,
    output logic             ram_wr_block,
    output logic [1:0]       pm_mode
);
    logic   pin_s;
    pmode_e mode;

    rpc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(rst_pin), .q(pin_s)
    );

    rpc_mcycle #(.CLKS_PER_MC(CLKS_PER_MC)) u_mcycle (
        .clk(clk), .rst_n(rst_n), .run(osc_run), .phase(mc_phase), .tick(mc_tick)
    );

    rpc_rst_seq #(.HOLD_CLKS(HOLD_CLKS)) u_rst (
        .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .run(osc_run),
        .core_rst(core_rst), .sfr_load(sfr_load)
    );

    rpc_mode_fsm u_mode (
        .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .core_rst(core_rst),
        .idle_req(idle_req), .pdown_req(pdown_req), .irq_pending(irq_pending),
        .mode(mode), .ram_blk(ram_wr_block)
    );

    // Clock enables and the asynchronous port force.
    assign osc_run    = (mode != MODE_PDOWN);
    assign periph_ce  = osc_run;
    assign cpu_ce     = (mode == MODE_RUN);
    assign ports_high = rst_pin || core_rst;
    assign pm_mode    = mode;

    // Publish the register defaults, one byte lane per register.
    for (genvar k = 0; k < SFR_LANES; k++) begin : g_lane
        assign sfr_rst_val[8*k +: 8] = sfr_default(k);
    end
endmodule

// File: rtl/rstpwr_ctrl_chk.sv
// Checker: temporal properties of the reset and power-mode sequencer,
// bound to every instance of the top module.
module rstpwr_ctrl_chk #(
    parameter int PW = 4,
    parameter int CLKS_PER_MC = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pin_s,
    input logic [PW-1:0] mc_phase,
    input logic          osc_run,
    input logic          core_rst,
    input logic          sfr_load,
    input logic          ports_high,
    input logic          cpu_ce,
    input logic          periph_ce,
    input logic          pdown_req,
    input logic          ram_wr_block,
    input logic [1:0]    pm_mode
);
    localparam logic [PW-1:0] LAST = PW'(CLKS_PER_MC - 1);

    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_run && mc_phase == LAST) |=> (mc_phase == '0)); // R1
    AST_PHASE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_run |=> $stable(mc_phase)); // R1
    AST_PORTS_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |-> ports_high); // R2
    AST_CORE_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |-> pin_s); // R3
    AST_LOAD_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst) |-> sfr_load); // R4
    AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_load |=> !sfr_load); // R4
    AST_IDLE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_mode == 2'd1) |-> (!cpu_ce && periph_ce)); // R6
    AST_PDOWN_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_mode == 2'd2) |-> (!osc_run && !periph_ce && !cpu_ce)); // R8
    AST_PDOWN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_mode == 2'd2 && !pin_s) |=> (pm_mode == 2'd2)); // R9
    AST_PDOWN_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_mode == 2'd0 && !pin_s && !core_rst && pdown_req) |=> (pm_mode == 2'd2)); // R10
    AST_RAM_BLOCK_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr_block |-> pin_s); // R11
endmodule

bind rstpwr_ctrl rstpwr_ctrl_chk #(.PW(PW), .CLKS_PER_MC(CLKS_PER_MC)) u_chk (
    .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .mc_phase(mc_phase),
    .osc_run(osc_run), .core_rst(core_rst), .sfr_load(sfr_load),
    .ports_high(ports_high), .cpu_ce(cpu_ce), .periph_ce(periph_ce),
    .pdown_req(pdown_req), .ram_wr_block(ram_wr_block), .pm_mode(pm_mode)
);

// File: tb/rstpwr_ctrl_test.sv
`timescale 1ns/1ps
module rstpwr_ctrl_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rst_pin = 1'b0;
    logic         idle_req = 1'b0;
    logic         pdown_req = 1'b0;
    logic         irq_pending = 1'b0;
    logic [3:0]   mc_phase;
    logic         mc_tick, core_rst, cpu_ce, periph_ce, osc_run, ports_high;
    logic         sfr_load, ram_wr_block;
    logic [119:0] sfr_rst_val;
    logic [1:0]   pm_mode;

    int n_run  = 0;
    int n_fail = 0;
    bit seen_core;

    rstpwr_ctrl uut (
        .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .idle_req(idle_req),
        .pdown_req(pdown_req), .irq_pending(irq_pending), .mc_phase(mc_phase),
        .mc_tick(mc_tick), .core_rst(core_rst), .cpu_ce(cpu_ce),
        .periph_ce(periph_ce), .osc_run(osc_run), .ports_high(ports_high),
        .sfr_load(sfr_load), .sfr_rst_val(sfr_rst_val),
        .ram_wr_block(ram_wr_block), .pm_mode(pm_mode)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) if (core_rst) seen_core = 1'b1;

    function automatic logic [7:0] exp_lane(input int k);
        return (k == 0) ? 8'h07 : (k == 1 || k == 2) ? 8'hFF : 8'h00;
    endfunction

    function automatic logic [1:0] exp_next(input logic [1:0] m, input bit i,
                                            input bit p, input bit q);
        if (m == 2'd0) return p ? 2'd2 : (i ? 2'd1 : 2'd0);
        if (m == 2'd1) return q ? 2'd0 : 2'd1;
        return 2'd2;
    endfunction

    function automatic bit exp_core(input int w);
        return w >= 25;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // Pin high for w edges, then low long enough for the reset to clear.
    task automatic pulse(input int w);
        rst_pin = 1'b1;
        tick(w);
        rst_pin = 1'b0;
        tick(4);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int unsigned seed;
        logic [1:0] m;
        int p0;
        seed = $urandom(32'd1234);

        // R12 reset state
        tick(3);
        chk(pm_mode == 0 && mc_phase == 0 && !core_rst && !sfr_load && !ram_wr_block,
            "R12 reset state", {pm_mode, mc_phase}, 0);
        rst_n = 1'b1;
        chk(cpu_ce && osc_run && periph_ce && !ports_high, "R12 enables", cpu_ce, 1);

        // R5 default lanes
        for (int k = 0; k < 15; k++)
            chk(sfr_rst_val[8*k +: 8] == exp_lane(k), "R5 lane", sfr_rst_val[8*k +: 8], exp_lane(k));

        // R1 phase counting and tick
        tick(1);
        p0 = mc_phase;
        tick(5);
        chk(mc_phase == (p0 + 5) % 12, "R1 phase advance", mc_phase, (p0 + 5) % 12);
        while (mc_phase != 11) tick(1);
        chk(mc_tick == 1'b1, "R1 tick at phase 11", mc_tick, 1);
        tick(1);
        chk(mc_phase == 0 && !mc_tick, "R1 wrap", mc_phase, 0);

        // R2 asynchronous port force, R3/R4 hold timing
        #1;
        rst_pin = 1'b1;
        #0.2;
        chk(ports_high == 1'b1, "R2 ports high without edge", ports_high, 1);
        @(posedge clk); #1;
        tick(24);
        chk(core_rst == 1'b0, "R3 no core reset after 25 edges", core_rst, 0);
        tick(1);
        chk(core_rst == 1'b1, "R3 core reset after 26 edges", core_rst, 1);
        chk(sfr_load == 1'b1, "R4 load on first cycle", sfr_load, 1);
        tick(1);
        chk(sfr_load == 1'b0, "R4 load one cycle", sfr_load, 0);
        rst_pin = 1'b0;
        tick(1);
        chk(core_rst == 1'b1 && ports_high == 1'b1, "R2 ports held by core reset", ports_high, 1);
        tick(1);
        chk(core_rst == 1'b0, "R3 release after 2 edges", core_rst, 0);

        // R6 idle entry, R7 interrupt exit
        idle_req = 1'b1; tick(1); idle_req = 1'b0;
        chk(pm_mode == 1 && !cpu_ce && periph_ce && osc_run, "R6 idle", pm_mode, 1);
        p0 = mc_phase;
        tick(3);
        chk(mc_phase == (p0 + 3) % 12, "R6 peripherals run in idle", mc_phase, (p0 + 3) % 12);
        irq_pending = 1'b1; tick(1); irq_pending = 1'b0;
        chk(pm_mode == 0 && cpu_ce, "R7 interrupt exits idle", pm_mode, 0);

        // R11 reset ends idle
        idle_req = 1'b1; tick(1); idle_req = 1'b0;
        rst_pin = 1'b1;
        tick(2);
        chk(pm_mode == 1 && !ram_wr_block, "R11 still idle after 2 edges", pm_mode, 1);
        tick(1);
        chk(pm_mode == 0 && ram_wr_block && cpu_ce, "R11 wake and block RAM", ram_wr_block, 1);
        tick(23);
        chk(core_rst && ram_wr_block, "R11 block held into core reset", core_rst, 1);
        rst_pin = 1'b0;
        tick(1);
        chk(ram_wr_block == 1'b1, "R11 block one edge after release", ram_wr_block, 1);
        tick(1);
        chk(ram_wr_block == 1'b0, "R11 block cleared", ram_wr_block, 0);
        tick(2);

        // R8 power-down, R9 exit only by reset
        pdown_req = 1'b1; tick(1); pdown_req = 1'b0;
        chk(pm_mode == 2 && !osc_run && !cpu_ce && !periph_ce, "R8 power-down", pm_mode, 2);
        p0 = mc_phase;
        irq_pending = 1'b1; idle_req = 1'b1; tick(3);
        irq_pending = 1'b0; idle_req = 1'b0; tick(2);
        chk(pm_mode == 2, "R8 interrupt and idle ignored", pm_mode, 2);
        chk(mc_phase == p0, "R1 phase frozen in power-down", mc_phase, p0);
        rst_pin = 1'b1;
        tick(2);
        chk(pm_mode == 2 && !osc_run, "R9 asleep after 2 edges", pm_mode, 2);
        tick(1);
        chk(pm_mode == 0 && osc_run, "R9 oscillator back after 3 edges", pm_mode, 0);
        tick(23);
        chk(core_rst == 1'b0, "R9 no core reset after 26 edges", core_rst, 0);
        tick(1);
        chk(core_rst == 1'b1, "R9 core reset after 27 edges", core_rst, 1);
        rst_pin = 1'b0;
        tick(4);

        // R10 priority
        idle_req = 1'b1; pdown_req = 1'b1; tick(1);
        idle_req = 1'b0; pdown_req = 1'b0;
        chk(pm_mode == 2, "R10 power-down wins", pm_mode, 2);
        pulse(30);
        chk(pm_mode == 0, "R9 reset exits power-down", pm_mode, 0);

        // R3 random pulse widths around the threshold
        for (int t = 0; t < 12; t++) begin
            int w;
            w = (t == 0) ? 24 : (t == 1) ? 25 : 1 + int'($urandom % 40);
            tick(2);
            seen_core = 1'b0;
            pulse(w);
            chk(seen_core == exp_core(w), "R3 pulse width", seen_core, exp_core(w));
        end

        // R6 R7 R8 R10 random strobes against the mode model
        m = 2'd0;
        for (int c = 0; c < 600; c++) begin
            bit i, p, q;
            i = ($urandom % 6) == 0;
            p = ($urandom % 40) == 0;
            q = ($urandom % 5) == 0;
            idle_req = i; pdown_req = p; irq_pending = q;
            tick(1);
            idle_req = 1'b0; pdown_req = 1'b0; irq_pending = 1'b0;
            m = exp_next(m, i, p, q);
            chk(pm_mode == m && cpu_ce == (m == 0) && periph_ce == (m != 2),
                "R6 R7 R8 random mode", pm_mode, m);
            if (m == 2'd2) begin
                pulse(30);
                m = 2'd0;
                chk(pm_mode == 0, "R9 random wake", pm_mode, 0);
            end
        end

        summary();
    end
endmodule